// File: doc/BRIEF.md
# Predicated Loop and Branch Sequencer

This block steers the instruction pointer of a small macro processor that issues two ALU operations and two output operations per instruction. Every cycle while running it presents the pointer to an external instruction memory, receives the 48-bit instruction word in the same cycle, and derives a four-bit enable mask: bit 0 gates ALU slot 0, bit 1 gates ALU slot 1, bit 2 gates output 0 and bit 3 gates output 1. The mask comes from a per-instruction predicate pattern and the truth of a predicate operand supplied by the register file.

Control-flow operations in either ALU slot redirect the pointer: five compare-and-branch forms with a sense bit and a 13-bit signed offset, a forward relative jump, and a zero-overhead hardware loop with count, start and end registers. A special branch offset halts execution, and an instruction's end flag halts execution only after the next instruction has run. The block also raises two parameter-queue pop strobes and reports illegal conditions through a sticky error flag.

Instruction word layout (bit positions): [15:0] immediate 0, [31:16] immediate 1, [35:32] slot 0 opcode, [39:36] slot 1 opcode, [43:40] predicate pattern, [44] always-execute, [45] end flag, [46] use parameter 0, [47] use parameter 1.

Top module: `seq_top`

## Requirements
- R1: After reset `running`, `finished`, `errFlag`, `unitEn`, `pop0` and `pop1` are all zero.
- R2: A `start` pulse while idle makes `running` high at the next edge with `imemAddr` equal to 0; while running, `imemAddr` is the current pointer and by default it advances by one per cycle.
- R3: With the always-execute bit set `unitEn` is 4'hF; otherwise `unitEn[i]` is 1 exactly when pattern bit i equals the truth of `predVal` (nonzero is true). When not running `unitEn` is zero.
- R4: Opcodes 1..5 are signed less-than, unsigned less-than, signed less-or-equal, unsigned less-or-equal and equal on the slot's x and y operands; the branch is taken when the compare result equals immediate bit 15, and the next pointer is the current pointer plus bits [12:0] of the immediate sign-extended.
- R5: A control-flow operation whose slot is disabled by `unitEn` has no effect on the pointer.
- R6: A taken branch whose 13-bit offset is 0x1000 (sign-extended 0xF000) ends execution after that instruction and pulses `finished`; no jump occurs.
- R7: Opcode 6 jumps forward by the unsigned immediate bits [14:0]; immediate bit 15 must be set.
- R8: Opcode 7 loads the loop count with max(1, x) - 1, the loop start with the current pointer and the loop end with pointer + immediate - 1; when the count is nonzero and the pointer equals the loop end, the count decrements and the next pointer is loop start + 1.
- R9: An instruction with the end flag set is followed by exactly one more instruction, after which `running` falls and `finished` is high for one cycle.
- R10: `pop0` is high during a running instruction that uses parameter 0; `pop1` is high when it uses both parameters.
- R11: A pointer target outside 0..0xFFF, a jump with immediate bit 15 clear, or use of parameter 1 without parameter 0 halts execution without `finished`, sets `errFlag`, and keeps it set until the next `start`.
- R12: When both slots redirect in the same instruction, slot 1's target wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin execution at pointer 0 when idle |
| imemAddr | output | 12 | Instruction pointer to instruction memory |
| imemData | input | 48 | Instruction word at `imemAddr`, same cycle |
| predVal | input | 32 | Predicate operand for the current instruction |
| aluX0 | input | 32 | Slot 0 first operand |
| aluY0 | input | 32 | Slot 0 second operand |
| aluX1 | input | 32 | Slot 1 first operand |
| aluY1 | input | 32 | Slot 1 second operand |
| unitEn | output | 4 | Enables for ALU0, ALU1, output0, output1 |
| pop0 | output | 1 | Pop strobe for the first parameter |
| pop1 | output | 1 | Pop strobe for the second parameter |
| running | output | 1 | Sequencer is executing |
| finished | output | 1 | One-cycle pulse on normal completion |
| errFlag | output | 1 | Sticky illegal-condition flag |

## Verification
The hardest behaviour to reach is the loop wrap interacting with the pointer: it needs a loop instruction whose operand sets a count, a body that reaches the end pointer several times, and an end flag placed just after the body so the delayed halt lands on a known instruction. The bench holds per-address operand and predicate tables so each instruction sees chosen x, y and predicate values, and compares the full fetched-pointer trace, including the repeated body addresses, against a queue of expected items. A zero-count loop, a predicated-off branch and a stop-offset branch are driven the same way to show the pointer is left alone.

// File: rtl/seq_pkg.sv
package seq_pkg;

  localparam int unsigned INST_W = 48;
  localparam int unsigned IMM_W  = 16;
  localparam int unsigned OP_W   = 4;
  localparam int unsigned UNITS  = 4;

  localparam logic [OP_W-1:0] OP_NOP  = 4'd0;
  localparam logic [OP_W-1:0] OP_BLT  = 4'd1;
  localparam logic [OP_W-1:0] OP_BLTU = 4'd2;
  localparam logic [OP_W-1:0] OP_BLE  = 4'd3;
  localparam logic [OP_W-1:0] OP_BLEU = 4'd4;
  localparam logic [OP_W-1:0] OP_BEQ  = 4'd5;
  localparam logic [OP_W-1:0] OP_JAL  = 4'd6;
  localparam logic [OP_W-1:0] OP_LOOP = 4'd7;

  // 13-bit branch offset value that means "halt"
  localparam logic [12:0] STOP_OFF = 13'h1000;

  typedef struct packed {
    logic             useLd1;
    logic             useLd0;
    logic             endFlag;
    logic             predAlways;
    logic [UNITS-1:0] predPat;
    logic [OP_W-1:0]  op1;
    logic [OP_W-1:0]  op0;
    logic [IMM_W-1:0] imm1;
    logic [IMM_W-1:0] imm0;
  } seqInst_t;

  typedef struct packed {
    logic restart;
    logic advance;
  } seqStrb_t;

endpackage

// File: rtl/seq_slot.sv
module seq_slot
  import seq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IP_W   = 12,
  localparam int unsigned TGT_W = IP_W + 5
) (
  input  logic [OP_W-1:0]   op,
  input  logic [IMM_W-1:0]  imm,
  input  logic              en,
  input  logic [DATA_W-1:0] x,
  input  logic [DATA_W-1:0] y,
  input  logic [IP_W-1:0]   ip,
  output logic              redirect,
  output logic [TGT_W-1:0]  target,
  output logic              stopHit,
  output logic              jalBad,
  output logic              loopSet,
  output logic [DATA_W-1:0] loopCnt,
  output logic [TGT_W-1:0]  loopEnd
);

  logic isBr, isJal, isLoop, cmpRes, taken;
  logic [TGT_W-1:0] ipW, offBr, offJal, immZ;

  assign ipW    = {{(TGT_W-IP_W){1'b0}}, ip};
  assign offBr  = {{(TGT_W-13){imm[12]}}, imm[12:0]};
  assign offJal = {{(TGT_W-15){1'b0}}, imm[14:0]};
  assign immZ   = {{(TGT_W-IMM_W){1'b0}}, imm};

  always_comb begin
    isBr   = 1'b0;
    cmpRes = 1'b0;
    unique case (op)
      OP_BLT:  begin isBr = 1'b1; cmpRes = $signed(x) <  $signed(y); end
      OP_BLTU: begin isBr = 1'b1; cmpRes = x <  y; end
      OP_BLE:  begin isBr = 1'b1; cmpRes = $signed(x) <= $signed(y); end
      OP_BLEU: begin isBr = 1'b1; cmpRes = x <= y; end
      OP_BEQ:  begin isBr = 1'b1; cmpRes = x == y; end
      default: begin isBr = 1'b0; cmpRes = 1'b0; end
    endcase
  end

  assign isJal  = (op == OP_JAL);
  assign isLoop = (op == OP_LOOP);

  assign taken    = en && isBr && (cmpRes == imm[15]);
  assign stopHit  = taken && (imm[12:0] == STOP_OFF);
  assign jalBad   = en && isJal && !imm[15];
  assign redirect = (taken && !stopHit) || (en && isJal && imm[15]);
  assign target   = ipW + (isJal ? offJal : offBr);

  assign loopSet  = en && isLoop;
  assign loopCnt  = (x == '0) ? '0 : x - 1'b1;
  assign loopEnd  = ipW + immZ - 1'b1;

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IP_W   = 12,
  localparam int unsigned TGT_W = IP_W + 5,
  localparam int unsigned SLOTS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqStrb_t          strb,
  input  logic [OP_W-1:0]   op0,
  input  logic [OP_W-1:0]   op1,
  input  logic [IMM_W-1:0]  imm0,
  input  logic [IMM_W-1:0]  imm1,
  input  logic [UNITS-1:0]  unitEn,
  input  logic [DATA_W-1:0] aluX0,
  input  logic [DATA_W-1:0] aluY0,
  input  logic [DATA_W-1:0] aluX1,
  input  logic [DATA_W-1:0] aluY1,
  output logic [IP_W-1:0]   ip,
  output logic              stopHit,
  output logic              jalBad,
  output logic              rangeErr
);

  logic [SLOTS-1:0][OP_W-1:0]   opArr;
  logic [SLOTS-1:0][IMM_W-1:0]  immArr;
  logic [SLOTS-1:0][DATA_W-1:0] xArr, yArr;
  logic [SLOTS-1:0]             redirArr, stopArr, jalBadArr, loopSetArr;
  logic [SLOTS-1:0][TGT_W-1:0]  tgtArr, loopEndArr;
  logic [SLOTS-1:0][DATA_W-1:0] loopCntArr;

  assign opArr  = {op1, op0};
  assign immArr = {imm1, imm0};
  assign xArr   = {aluX1, aluX0};
  assign yArr   = {aluY1, aluY0};

  for (genvar g = 0; g < SLOTS; g++) begin : gSlot
    seq_slot #(.DATA_W(DATA_W), .IP_W(IP_W)) uSlot (
      .op      (opArr[g]),
      .imm     (immArr[g]),
      .en      (unitEn[g]),
      .x       (xArr[g]),
      .y       (yArr[g]),
      .ip      (ip),
      .redirect(redirArr[g]),
      .target  (tgtArr[g]),
      .stopHit (stopArr[g]),
      .jalBad  (jalBadArr[g]),
      .loopSet (loopSetArr[g]),
      .loopCnt (loopCntArr[g]),
      .loopEnd (loopEndArr[g])
    );
  end

  logic [DATA_W-1:0] loopCntR;
  logic [IP_W-1:0]   loopStartR;
  logic [TGT_W-1:0]  loopEndR;
  logic [TGT_W-1:0]  ipW, nextIp;
  logic              loopWrap;

  assign ipW      = {{(TGT_W-IP_W){1'b0}}, ip};
  assign loopWrap = (loopCntR != '0) && (ipW == loopEndR);

  always_comb begin
    nextIp = ipW + 1'b1;
    for (int s = 0; s < SLOTS; s++) begin
      if (redirArr[s]) nextIp = tgtArr[s];
    end
    if (loopWrap) nextIp = {{(TGT_W-IP_W){1'b0}}, loopStartR} + 1'b1;
  end

  assign stopHit  = |stopArr;
  assign jalBad   = |jalBadArr;
  assign rangeErr = nextIp[TGT_W-1:IP_W] != '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ip         <= '0;
      loopCntR   <= '0;
      loopStartR <= '0;
      loopEndR   <= '0;
    end else if (strb.restart) begin
      ip         <= '0;
      loopCntR   <= '0;
      loopStartR <= '0;
      loopEndR   <= '0;
    end else if (strb.advance) begin
      ip <= nextIp[IP_W-1:0];
      if (loopSetArr[1]) begin
        loopCntR   <= loopCntArr[1];
        loopStartR <= ip;
        loopEndR   <= loopEndArr[1];
      end else if (loopSetArr[0]) begin
        loopCntR   <= loopCntArr[0];
        loopStartR <= ip;
        loopEndR   <= loopEndArr[0];
      end else if (loopWrap) begin
        loopCntR <= loopCntR - 1'b1;
      end
    end
  end

  // R2
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.restart |=> (ip == '0));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.advance && !strb.restart) |=> $stable(ip));

  // R8
  loop_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.advance && loopWrap && !(|loopSetArr)) |=> (ip == IP_W'($past(loopStartR) + 1'b1)));

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              endFlag,
  input  logic              useLd0,
  input  logic              useLd1,
  input  logic              predAlways,
  input  logic [UNITS-1:0]  predPat,
  input  logic [DATA_W-1:0] predVal,
  input  logic              stopHit,
  input  logic              jalBad,
  input  logic              rangeErr,
  output seqStrb_t          strb,
  output logic [UNITS-1:0]  unitEn,
  output logic              pop0,
  output logic              pop1,
  output logic              running,
  output logic              finished,
  output logic              errFlag
);

  logic endPending, predTrue, loadBad, anyErr, normalHalt;

  assign predTrue   = |predVal;
  assign loadBad    = useLd1 && !useLd0;
  assign normalHalt = stopHit || endPending;
  assign anyErr     = jalBad || loadBad || (rangeErr && !normalHalt);

  always_comb begin
    if (!running)        unitEn = '0;
    else if (predAlways) unitEn = '1;
    else                 unitEn = predPat ~^ {UNITS{predTrue}};
  end

  assign pop0 = running && useLd0;
  assign pop1 = running && useLd0 && useLd1;

  assign strb.restart = !running && start;
  assign strb.advance = running && !anyErr && !normalHalt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running    <= 1'b0;
      endPending <= 1'b0;
      finished   <= 1'b0;
      errFlag    <= 1'b0;
    end else begin
      finished <= 1'b0;
      if (!running) begin
        if (start) begin
          running    <= 1'b1;
          endPending <= 1'b0;
          errFlag    <= 1'b0;
        end
      end else if (anyErr) begin
        running <= 1'b0;
        errFlag <= 1'b1;
      end else if (normalHalt) begin
        running  <= 1'b0;
        finished <= 1'b1;
      end else begin
        endPending <= endFlag;
      end
    end
  end

  // R9
  finished_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finished |=> !finished);

  // R11
  err_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(errFlag) |-> ($past(running) && !running && !finished));

  // R9
  end_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && endFlag && !anyErr && !normalHalt) |=> running);

endmodule

// File: rtl/seq_top.sv
module seq_top
  import seq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IP_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [IP_W-1:0]   imemAddr,
  input  logic [INST_W-1:0] imemData,
  input  logic [DATA_W-1:0] predVal,
  input  logic [DATA_W-1:0] aluX0,
  input  logic [DATA_W-1:0] aluY0,
  input  logic [DATA_W-1:0] aluX1,
  input  logic [DATA_W-1:0] aluY1,
  output logic [UNITS-1:0]  unitEn,
  output logic              pop0,
  output logic              pop1,
  output logic              running,
  output logic              finished,
  output logic              errFlag
);

  seqInst_t inst;
  seqStrb_t strb;
  logic     stopHit, jalBad, rangeErr;

  assign inst = seqInst_t'(imemData);

  seq_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .endFlag   (inst.endFlag),
    .useLd0    (inst.useLd0),
    .useLd1    (inst.useLd1),
    .predAlways(inst.predAlways),
    .predPat   (inst.predPat),
    .predVal   (predVal),
    .stopHit   (stopHit),
    .jalBad    (jalBad),
    .rangeErr  (rangeErr),
    .strb      (strb),
    .unitEn    (unitEn),
    .pop0      (pop0),
    .pop1      (pop1),
    .running   (running),
    .finished  (finished),
    .errFlag   (errFlag)
  );

  seq_datapath #(.DATA_W(DATA_W), .IP_W(IP_W)) uDp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .op0     (inst.op0),
    .op1     (inst.op1),
    .imm0    (inst.imm0),
    .imm1    (inst.imm1),
    .unitEn  (unitEn),
    .aluX0   (aluX0),
    .aluY0   (aluY0),
    .aluX1   (aluX1),
    .aluY1   (aluY1),
    .ip      (imemAddr),
    .stopHit (stopHit),
    .jalBad  (jalBad),
    .rangeErr(rangeErr)
  );

endmodule

// File: tb/tb_seq_top.sv
module tb_seq_top;

  localparam int DATA_W = 32;
  localparam int IP_W   = 12;
  localparam int MEM_N  = 64;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, start;
  logic [IP_W-1:0] imemAddr;
  logic [47:0] imemData;
  logic [DATA_W-1:0] predVal, aluX0, aluY0, aluX1, aluY1;
  logic [3:0] unitEn;
  logic pop0, pop1, running, finished, errFlag;

  logic [47:0] mem [MEM_N];
  logic [DATA_W-1:0] tx0 [MEM_N];
  logic [DATA_W-1:0] ty0 [MEM_N];
  logic [DATA_W-1:0] tx1 [MEM_N];
  logic [DATA_W-1:0] ty1 [MEM_N];
  logic [DATA_W-1:0] tpv [MEM_N];

  int nChk = 0;
  int nBad = 0;
  string curReq = "R1";
  logic [17:0] expQ [$];

  function automatic logic [47:0] mk(logic [3:0] o0, logic [15:0] i0, logic [3:0] o1,
                                     logic [15:0] i1, logic alw, logic [3:0] pat,
                                     logic e, logic l0, logic l1);
    return {l1, l0, e, alw, pat, o1, o0, i1, i0};
  endfunction

  localparam logic [47:0] NOPI = {3'b000, 1'b1, 44'h0};

  always_comb begin
    if (imemAddr < IP_W'(MEM_N)) begin
      imemData = mem[imemAddr[5:0]];
      aluX0    = tx0[imemAddr[5:0]];
      aluY0    = ty0[imemAddr[5:0]];
      aluX1    = tx1[imemAddr[5:0]];
      aluY1    = ty1[imemAddr[5:0]];
      predVal  = tpv[imemAddr[5:0]];
    end else begin
      imemData = NOPI;
      aluX0 = '0; aluY0 = '0; aluX1 = '0; aluY1 = '0; predVal = '0;
    end
  end

  seq_top dut (
    .clk(clk), .rst_n(rst_n), .start(start), .imemAddr(imemAddr), .imemData(imemData),
    .predVal(predVal), .aluX0(aluX0), .aluY0(aluY0), .aluX1(aluX1), .aluY1(aluY1),
    .unitEn(unitEn), .pop0(pop0), .pop1(pop1), .running(running),
    .finished(finished), .errFlag(errFlag)
  );

  // monitor: compares each fetched instruction against the scoreboard
  always @(negedge clk) begin
    if (rst_n && running) begin
      logic [17:0] got;
      got = {imemAddr, unitEn, pop0, pop1};
      nChk++;
      if (expQ.size() == 0) begin
        nBad++;
        $display("FAIL %s trace: actual ip=%0d en=%b pops=%b%b expected none", curReq,
                 imemAddr, unitEn, pop0, pop1);
      end else begin
        logic [17:0] e;
        e = expQ.pop_front();
        if (e !== got) begin
          nBad++;
          $display("FAIL %s trace: actual ip=%0d en=%b pops=%b%b expected ip=%0d en=%b pops=%b%b",
                   curReq, got[17:6], got[5:2], got[1], got[0], e[17:6], e[5:2], e[1], e[0]);
        end
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clearProg();
    for (int i = 0; i < MEM_N; i++) begin
      mem[i] = NOPI; tx0[i] = '0; ty0[i] = '0; tx1[i] = '0; ty1[i] = '0; tpv[i] = '0;
    end
    expQ.delete();
  endtask

  task automatic push(int ip, logic [3:0] en, logic p0, logic p1);
    expQ.push_back({ip[11:0], en, p0, p1});
  endtask

  task automatic run(string req, logic expFin, logic expErr);
    int n;
    curReq = req;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 0;
    while (running && n < 400) begin
      @(negedge clk);
      n++;
    end
    if (n >= 400) begin
      nBad++;
      $display("FAIL %s: run did not end, actual running=1 expected 0", req);
    end
    check({req, " finished"}, {31'b0, finished}, {31'b0, expFin});
    check({req, " errFlag"}, {31'b0, errFlag}, {31'b0, expErr});
    check({req, " leftover"}, expQ.size(), 0);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0;
    clearProg();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 running", {31'b0, running}, 0);
    check("R1 finished", {31'b0, finished}, 0);
    check("R1 errFlag", {31'b0, errFlag}, 0);
    check("R1 unitEn", {28'b0, unitEn}, 0);
    check("R1 pops", {30'b0, pop0, pop1}, 0);

    // R9 / R2: delayed end flag
    clearProg();
    mem[1] = mk(0, 0, 0, 0, 1, 0, 1, 0, 0);
    push(0, 4'hF, 0, 0); push(1, 4'hF, 0, 0); push(2, 4'hF, 0, 0);
    run("R9", 1, 0);

    // R3 predicate mask
    clearProg();
    mem[0] = mk(0, 0, 0, 0, 0, 4'b0101, 0, 0, 0); tpv[0] = 5;
    mem[1] = mk(0, 0, 0, 0, 0, 4'b0101, 1, 0, 0); tpv[1] = 0;
    push(0, 4'b0101, 0, 0); push(1, 4'b1010, 0, 0); push(2, 4'hF, 0, 0);
    run("R3", 1, 0);

    // R4 branch compares, sense bit, signed offset
    clearProg();
    mem[0] = mk(1, 16'h8003, 0, 0, 1, 0, 0, 0, 0); tx0[0] = 32'hFFFF_FFFF; ty0[0] = 1;
    mem[3] = mk(2, 16'h8005, 0, 0, 1, 0, 0, 0, 0); tx0[3] = 32'hFFFF_FFFF; ty0[3] = 1;
    mem[4] = mk(5, 16'h1FFD, 0, 0, 1, 0, 0, 0, 0); tx0[4] = 1; ty0[4] = 2;
    mem[1] = mk(0, 0, 0, 0, 1, 0, 1, 0, 0);
    push(0, 4'hF, 0, 0); push(3, 4'hF, 0, 0); push(4, 4'hF, 0, 0);
    push(1, 4'hF, 0, 0); push(2, 4'hF, 0, 0);
    run("R4", 1, 0);

    // R5 predicated-off branch has no effect
    clearProg();
    mem[0] = mk(5, 16'h8005, 0, 0, 0, 4'b1110, 1, 0, 0); tpv[0] = 1;
    push(0, 4'b1110, 0, 0); push(1, 4'hF, 0, 0);
    run("R5", 1, 0);

    // R6 stop offset
    clearProg();
    mem[0] = mk(5, 16'h9000, 0, 0, 1, 0, 0, 0, 0);
    push(0, 4'hF, 0, 0);
    run("R6", 1, 0);

    // R7 forward jump in slot 1
    clearProg();
    mem[0] = mk(0, 0, 6, 16'h8004, 1, 0, 0, 0, 0);
    mem[4] = mk(0, 0, 0, 0, 1, 0, 1, 0, 0);
    push(0, 4'hF, 0, 0); push(4, 4'hF, 0, 0); push(5, 4'hF, 0, 0);
    run("R7", 1, 0);

    // R12 slot 1 wins
    clearProg();
    mem[0] = mk(6, 16'h8002, 6, 16'h8005, 1, 0, 0, 0, 0);
    mem[5] = mk(0, 0, 0, 0, 1, 0, 1, 0, 0);
    push(0, 4'hF, 0, 0); push(5, 4'hF, 0, 0); push(6, 4'hF, 0, 0);
    run("R12", 1, 0);

    // R8 loop with count 3
    clearProg();
    mem[0] = mk(7, 16'd3, 0, 0, 1, 0, 0, 0, 0); tx0[0] = 3;
    mem[3] = mk(0, 0, 0, 0, 1, 0, 1, 0, 0);
    push(0, 4'hF, 0, 0);
    for (int k = 0; k < 3; k++) begin push(1, 4'hF, 0, 0); push(2, 4'hF, 0, 0); end
    push(3, 4'hF, 0, 0); push(4, 4'hF, 0, 0);
    run("R8", 1, 0);

    // R8 loop with x = 0 runs the body once
    tx0[0] = 0;
    push(0, 4'hF, 0, 0); push(1, 4'hF, 0, 0); push(2, 4'hF, 0, 0);
    push(3, 4'hF, 0, 0); push(4, 4'hF, 0, 0);
    run("R8 zero", 1, 0);

    // R10 pop strobes
    clearProg();
    mem[0] = mk(0, 0, 0, 0, 1, 0, 0, 1, 0);
    mem[1] = mk(0, 0, 0, 0, 1, 0, 1, 1, 1);
    push(0, 4'hF, 1, 0); push(1, 4'hF, 1, 1); push(2, 4'hF, 0, 0);
    run("R10", 1, 0);

    // R11 jump without bit 15
    clearProg();
    mem[0] = mk(6, 16'h0004, 0, 0, 1, 0, 0, 0, 0);
    push(0, 4'hF, 0, 0);
    run("R11 jal", 0, 1);

    // R11 target below zero
    clearProg();
    mem[0] = mk(5, 16'h9FFF, 0, 0, 1, 0, 0, 0, 0);
    push(0, 4'hF, 0, 0);
    run("R11 range", 0, 1);

    // R11 second parameter alone
    clearProg();
    mem[0] = mk(0, 0, 0, 0, 1, 0, 0, 0, 1);
    push(0, 4'hF, 0, 0);
    run("R11 load", 0, 1);

    // R11 sticky until next start, then cleared
    check("R11 sticky", {31'b0, errFlag}, 1);
    clearProg();
    mem[0] = mk(0, 0, 0, 0, 1, 0, 1, 0, 0);
    push(0, 4'hF, 0, 0); push(1, 4'hF, 0, 0);
    run("R11 clear", 1, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule